// File: doc/BRIEF.md
# Compare-Based Pulse Generator Timer

This block makes a rectangular waveform from a 24-bit up-counter and two compare values. The counter advances once for each cycle on which the count enable is high and a tick from an external prescaler is present. When the count equals the first compare value (the duty point), the output flip-flop inverts and counting goes on. When the count equals the second compare value (the period end), the flip-flop inverts again and the counter returns to zero. The first compare value is meant to be smaller than the second.

Software picks the starting level of the output by writing an initial-level bit while the counter is stopped. Each compare has a sticky status flag, which is set by its match and cleared by a one-cycle clear strobe. Each flag has its own enable. The enabled flags are combined into one active-low interrupt request. All logic runs on a single system clock.

Top module: `pulse_timer`

## Requirements
- R1: While `run` is 1, `count` increases by one on each clock edge where `tick` is 1. It holds on edges where `tick` is 0.
- R2: While `run` is 0, `count` and `wave` hold, whatever `tick` does.
- R3: On a stepping edge where `count` equals `duty_cmp` and does not equal `period_cmp`, `wave` inverts and `count` still increments.
- R4: On a stepping edge where `count` equals `period_cmp`, `wave` inverts and `count` becomes 0 on the next cycle.
- R5: If `lvl_wr` is 1 while `run` is 0, `wave` takes `lvl_init` on the next cycle. If `run` is 1, `lvl_wr` has no effect.
- R6: A duty match sets `flag_duty` and a period match sets `flag_period`. Each flag stays at 1 until its clear strobe (`clr_duty` or `clr_period`) is 1 on an edge.
- R7: If a match and the clear strobe for the same flag fall on the same edge, the flag ends up at 1.
- R8: `irq_n` is 0 exactly when (`flag_duty` and `ien_duty`) or (`flag_period` and `ien_period`) is true. Otherwise it is 1.
- R9: When `duty_cmp` >= `period_cmp`, no duty event occurs: `flag_duty` is never set, and `wave` inverts once per period.
- R10: After reset, `count` is 0, `wave` is 0, both flags are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable |
| tick | input | 1 | Prescaler tick; one step per high cycle |
| duty_cmp | input | 24 | Duty-point compare value |
| period_cmp | input | 24 | Period-end compare value |
| lvl_init | input | 1 | Initial output level |
| lvl_wr | input | 1 | Load strobe for `lvl_init` |
| ien_duty | input | 1 | Interrupt enable for the duty flag |
| ien_period | input | 1 | Interrupt enable for the period flag |
| clr_duty | input | 1 | Clear strobe for the duty flag |
| clr_period | input | 1 | Clear strobe for the period flag |
| count | output | 24 | Current counter value |
| wave | output | 1 | Pulse output |
| flag_duty | output | 1 | Sticky duty-match status |
| flag_period | output | 1 | Sticky period-match status |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that the inputs are synchronous to `clk` and that the counter never steps past the 24-bit limit without meeting `period_cmp`. The second assumption holds because `period_cmp` is fixed while the timer runs. The stimulus changes inputs just after a rising edge and sets up the compare values only while `run` is 0. It keeps `period_cmp` small so that every run wraps through many periods. The swapped-order case (R9) is covered by a separate run with `duty_cmp` above `period_cmp`.

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] duty_cmp,
  input  logic [W-1:0] period_cmp,
  input  logic         lvl_init,
  input  logic         lvl_wr,
  input  logic         ien_duty,
  input  logic         ien_period,
  input  logic         clr_duty,
  input  logic         clr_period,
  output logic [W-1:0] count,
  output logic         wave,
  output logic         flag_duty,
  output logic         flag_period,
  output logic         irq_n
);

  logic step, hit_a, hit_b;

  assign step  = run & tick;
  assign hit_b = step & (count == period_cmp);
  assign hit_a = step & (count == duty_cmp) & ~hit_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (hit_b) count <= '0;
    else if (step)  count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wave <= 1'b0;
    else if (hit_a | hit_b)   wave <= ~wave;
    else if (!run && lvl_wr)  wave <= lvl_init;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_duty   <= 1'b0;
      flag_period <= 1'b0;
    end else begin
      flag_duty   <= hit_a | (flag_duty & ~clr_duty);
      flag_period <= hit_b | (flag_period & ~clr_period);
    end
  end

  assign irq_n = ~((flag_duty & ien_duty) | (flag_period & ien_period));

endmodule

// File: rtl/pulse_timer_chk.sv
module pulse_timer_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         tick,
  input logic [W-1:0] duty_cmp,
  input logic [W-1:0] period_cmp,
  input logic         clr_period,
  input logic         ien_duty,
  input logic         ien_period,
  input logic [W-1:0] count,
  input logic         wave,
  input logic         flag_duty,
  input logic         flag_period,
  input logic         irq_n
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  assert_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(count) && $stable(wave));

  assert_duty_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count == duty_cmp && count != period_cmp)
      |=> (wave != $past(wave)) && flag_duty && (count == $past(count) + 1'b1));

  assert_period_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count == period_cmp) |=> (count == '0) && (wave != $past(wave)));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count == period_cmp && clr_period) |=> flag_period);

  assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_duty && !ien_period) |-> irq_n);

  assert_flag_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_period && ien_period) |-> !irq_n);

endmodule

bind pulse_timer pulse_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
  .duty_cmp(duty_cmp), .period_cmp(period_cmp), .clr_period(clr_period),
  .ien_duty(ien_duty), .ien_period(ien_period),
  .count(count), .wave(wave), .flag_duty(flag_duty),
  .flag_period(flag_period), .irq_n(irq_n)
);

// File: tb/test_pulse_timer.sv
module test_pulse_timer;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic run = 0, tick = 0, lvl_init = 0, lvl_wr = 0;
  logic ien_duty = 0, ien_period = 0, clr_duty = 0, clr_period = 0;
  logic [23:0] duty_cmp = 0, period_cmp = 0;
  logic [23:0] count;
  logic wave, flag_duty, flag_period, irq_n;

  int tests = 0, fails = 0;
  int m_cnt = 0;
  bit m_wave = 0, m_fa = 0, m_fb = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pulse_timer i_pulse_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .duty_cmp(duty_cmp), .period_cmp(period_cmp),
    .lvl_init(lvl_init), .lvl_wr(lvl_wr),
    .ien_duty(ien_duty), .ien_period(ien_period),
    .clr_duty(clr_duty), .clr_period(clr_period),
    .count(count), .wave(wave), .flag_duty(flag_duty),
    .flag_period(flag_period), .irq_n(irq_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_wave = 0; m_fa = 0; m_fb = 0;
    end else begin
      bit sa, sb;
      sa = 0; sb = 0;
      if (run && tick) begin
        if (m_cnt == int'(period_cmp)) begin
          m_cnt = 0; m_wave = !m_wave; sb = 1;
        end else begin
          if (m_cnt == int'(duty_cmp)) begin m_wave = !m_wave; sa = 1; end
          m_cnt = (m_cnt + 1) % (1 << 24);
        end
      end else if (!run && lvl_wr) m_wave = lvl_init;
      m_fa = sa || (m_fa && !clr_duty);
      m_fb = sb || (m_fb && !clr_period);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit m_irq;
    m_irq = !((m_fa && ien_duty) || (m_fb && ien_period));
    chk(int'(count) == m_cnt, "R1 R2 R4 count", int'(count), m_cnt);
    chk(wave == m_wave, "R3 R4 R5 wave", wave, m_wave);
    chk(flag_duty == m_fa, "R6 R9 flag_duty", flag_duty, m_fa);
    chk(flag_period == m_fb, "R6 R7 flag_period", flag_period, m_fb);
    chk(irq_n == m_irq, "R8 irq_n", irq_n, m_irq);
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD*3);
    chk(count == 0 && wave == 0 && !flag_duty && !flag_period && irq_n,
        "R10 reset", int'(count), 0);
    @(posedge clk); #1; rst_n = 1;
    duty_cmp = 3; period_cmp = 7;
    lvl_init = 1; lvl_wr = 1; cyc(1); lvl_wr = 0;
    @(negedge clk); chk(wave == 1, "R5 init load", wave, 1);
    @(posedge clk); #1;
    ien_duty = 1; run = 1; tick = 1;
    cyc(20);
    lvl_init = 0; lvl_wr = 1; cyc(1); lvl_wr = 0;
    for (int i = 0; i < 60; i++) begin
      tick = ($urandom % 3) != 0;
      if (i == 30) ien_period = 1;
      clr_duty = (i % 7) == 0;
      cyc(1);
      clr_duty = 0;
    end
    run = 0;
    @(negedge clk);
    begin
      int held;
      held = int'(count);
      cyc(5);
      @(negedge clk); chk(int'(count) == held, "R2 hold", int'(count), held);
    end
    @(posedge clk); #1;
    clr_duty = 1; clr_period = 1; cyc(1); clr_duty = 0; clr_period = 0;
    run = 1; tick = 1; clr_period = 1;
    for (int i = 0; i < 30; i++) begin
      cyc(1);
      if (m_cnt == 0) begin
        @(negedge clk); chk(flag_period == 1, "R7 set wins", flag_period, 1);
        @(posedge clk); #1;
      end
    end
    clr_period = 0;
    run = 0; cyc(1);
    clr_duty = 1; clr_period = 1; cyc(1); clr_duty = 0; clr_period = 0;
    rst_n = 0; cyc(1); rst_n = 1;
    duty_cmp = 9; period_cmp = 4; run = 1; tick = 1;
    cyc(40);
    @(negedge clk); chk(flag_duty == 0, "R9 no duty event", flag_duty, 0);
    ien_duty = 0; ien_period = 0;
    @(negedge clk); chk(irq_n == 1, "R8 masked", irq_n, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule